// File: doc/BRIEF.md
# Hybrid Integrator Digital Channel

This block is the digital half of one integrator in a hybrid-code differential analyzer. A variable is the sum of a coarse signed integer and an analog interpolation voltage. The block holds the coarse part of the integrand in a small signed register. Upstream elements step that register by one unit, using a pulse together with a direction level. The block also keeps a wider signed remainder register. That register collects the running sum of the integrand, scaled so that one output unit equals 2^(IW+1) remainder LSBs. The analog side watches the interpolation voltage and reports it through two comparator flags. From these flags the block derives the output carries it sends downstream, in the same pulse-plus-direction form.

A computing run alternates between COMPUTE intervals, where every register is frozen, and short HOLD intervals. In a HOLD interval a sequencer issues three step strobes in a fixed order: take in the upstream increment, add the integrand into the remainder, then resolve the output carry. A separate initialisation mode clears the state or loads initial values. Both registers are presented as outputs for the external converters. Any result that would leave a register's signed range is clipped to the limit and recorded in a sticky flag. When both comparator flags are raised together, the block treats it as a contradiction and sets a sticky fault.

Top module: `hyb_int_digital`

## Requirements
- R1: While `in_reset` is high and `init_load` is low, the next edge clears the integrand, the remainder, any pending increment, `out_pulse`, `fault` and `ovf`. `in_reset` takes priority over every HOLD strobe.
- R2: While `in_reset` and `init_load` are both high, the next edge loads `ic_integrand` into the integrand and `ic_remainder` into the remainder, and clears the pending increment, `fault` and `ovf`.
- R3: An `inc_pulse` is latched as pending together with `inc_sign` (0 means +1, 1 means −1). At the next `stb_inc` edge with `in_hold` high, the pending unit is added to the integrand and consumed. Without a pending increment, `stb_inc` leaves the integrand unchanged.
- R4: A `stb_acc` edge with `in_hold` high adds the sign-extended integrand to the remainder.
- R5: At a `stb_carry` edge with `in_hold` high, `cmp_hi` alone subtracts 2^(IW+1) (64 by default) from the remainder and gives a one-cycle `out_pulse` with `out_sign`=0. `cmp_lo` alone adds 2^(IW+1) and gives `out_pulse` with `out_sign`=1.
- R6: A `stb_carry` edge with neither flag raised produces no `out_pulse` and leaves the remainder unchanged. `out_pulse` is only ever high in the cycle after a `stb_carry` edge taken in HOLD.
- R7: A `stb_carry` edge with both flags raised produces no pulse and leaves the remainder unchanged. It sets `fault`, which stays set until R1 or R2 applies.
- R8: An integrand step past +2^IW−1 or below −2^IW holds the integrand at that limit and sets the sticky `ovf`.
- R9: A remainder update past +2^RW−1 or below −2^RW holds the remainder at that limit and sets the sticky `ovf`.
- R10: While `in_hold` is low, the step strobes have no effect, and the integrand and remainder stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_reset | input | 1 | Initialisation mode of the run |
| init_load | input | 1 | Load initial values while in initialisation mode |
| ic_integrand | input | IW+1 | Initial integrand, two's complement |
| ic_remainder | input | RW+1 | Initial remainder, two's complement |
| in_hold | input | 1 | HOLD interval active |
| stb_inc | input | 1 | Step strobe: apply pending upstream increment |
| stb_acc | input | 1 | Step strobe: add integrand into remainder |
| stb_carry | input | 1 | Step strobe: resolve output carry |
| inc_pulse | input | 1 | Upstream increment pulse |
| inc_sign | input | 1 | Upstream increment direction, 1 = down |
| cmp_hi | input | 1 | Analog part at or above +half unit |
| cmp_lo | input | 1 | Analog part at or below −half unit |
| integrand | output | IW+1 | Integrand register |
| remainder | output | RW+1 | Remainder register |
| out_pulse | output | 1 | Output carry pulse, one cycle |
| out_sign | output | 1 | Direction of the last output carry, 1 = down |
| fault | output | 1 | Sticky: both comparator flags seen together |
| ovf | output | 1 | Sticky: a register was clipped at its range limit |

## Verification
The hardest situation to reach from the ports is remainder saturation in each direction. A carry moves the remainder by only 64 LSBs, and ordinary carries pull it back toward zero, so it seldom comes near its limits on its own. Directed steps therefore load a remainder close to a limit and an integrand of the same sign, then strobe the accumulate step. Random frames use comparator flags chosen from the current remainder, with occasional contradictory pairs. Repeated same-sign increments push the integrand into its limits, and the initialisation mode clears the state from time to time.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
   typedef enum logic [1:0] {
      CY_NONE = 2'd0,
      CY_UP   = 2'd1,
      CY_DOWN = 2'd2,
      CY_BAD  = 2'd3
   } carry_e;

   function automatic carry_e decode_flags(input logic hi, input logic lo);
      case ({hi, lo})
         2'b10:   return CY_UP;
         2'b01:   return CY_DOWN;
         2'b11:   return CY_BAD;
         default: return CY_NONE;
      endcase
   endfunction
endpackage

// File: rtl/hyb_sat_add.sv
module hyb_sat_add #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] y,
   output logic                ovf
);
   localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic signed [W:0] wide;

   assign wide = {a[W-1], a} + {b[W-1], b};
   assign ovf  = wide[W] ^ wide[W-1];

   generate
      if (SATURATE) begin : g_sat
         assign y = ovf ? (wide[W] ? MINV : MAXV) : wide[W-1:0];
      end else begin : g_wrap
         assign y = wide[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/hyb_integrand_reg.sv
module hyb_integrand_reg #(
   parameter int IW       = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_reset,
   input  logic          init_load,
   input  logic [IW:0]   ic_val,
   input  logic          inc_pulse,
   input  logic          inc_sign,
   input  logic          step_en,
   output logic [IW:0]   val,
   output logic          ovf_evt
);
   localparam int W = IW + 1;

   logic          pend;
   logic          pend_neg;
   logic          do_step;
   logic [W-1:0]  step_b;
   logic [W-1:0]  sum;
   logic          add_ovf;

   assign do_step = step_en & pend;
   assign step_b  = pend_neg ? {W{1'b1}} : {{(W-1){1'b0}}, 1'b1};
   assign ovf_evt = do_step & add_ovf;

   hyb_sat_add #(.W(W), .SATURATE(SATURATE)) u_add (
      .a   (val),
      .b   (step_b),
      .y   (sum),
      .ovf (add_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val      <= '0;
         pend     <= 1'b0;
         pend_neg <= 1'b0;
      end else if (in_reset) begin
         val      <= init_load ? ic_val : '0;
         pend     <= 1'b0;
         pend_neg <= 1'b0;
      end else begin
         if (do_step) val <= sum;
         if (inc_pulse) begin
            pend     <= 1'b1;
            pend_neg <= inc_sign;
         end else if (do_step) begin
            pend     <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hyb_remainder_reg.sv
module hyb_remainder_reg
   import hyb_pkg::*;
#(
   parameter int IW       = 5,
   parameter int RW       = 7,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_reset,
   input  logic          init_load,
   input  logic [RW:0]   ic_val,
   input  logic          acc_en,
   input  logic [IW:0]   integrand,
   input  carry_e        carry,
   output logic [RW:0]   val,
   output logic          ovf_evt
);
   localparam int            W        = RW + 1;
   localparam int            UNIT_EXP = IW + 1;
   localparam logic [W-1:0]  UNIT     = {{(W-1){1'b0}}, 1'b1} << UNIT_EXP;
   localparam logic [W-1:0]  NEG_UNIT = ~UNIT + {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] operand;
   logic         upd;
   logic [W-1:0] sum;
   logic         add_ovf;

   always_comb begin
      operand = '0;
      upd     = 1'b0;
      if (carry == CY_UP) begin
         operand = NEG_UNIT;
         upd     = 1'b1;
      end else if (carry == CY_DOWN) begin
         operand = UNIT;
         upd     = 1'b1;
      end else if (acc_en) begin
         operand = {{(RW-IW){integrand[IW]}}, integrand};
         upd     = 1'b1;
      end
   end

   assign ovf_evt = upd & add_ovf;

   hyb_sat_add #(.W(W), .SATURATE(SATURATE)) u_add (
      .a   (val),
      .b   (operand),
      .y   (sum),
      .ovf (add_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        val <= '0;
      else if (in_reset) val <= init_load ? ic_val : '0;
      else if (upd)      val <= sum;
   end
endmodule

// File: rtl/hyb_carry_unit.sv
module hyb_carry_unit
   import hyb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    in_reset,
   input  logic    fire,
   input  logic    cmp_hi,
   input  logic    cmp_lo,
   output carry_e  carry,
   output logic    out_pulse,
   output logic    out_sign,
   output logic    fault
);
   logic emit;

   assign carry = fire ? decode_flags(cmp_hi, cmp_lo) : CY_NONE;
   assign emit  = (carry == CY_UP) || (carry == CY_DOWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pulse <= 1'b0;
         out_sign  <= 1'b0;
         fault     <= 1'b0;
      end else if (in_reset) begin
         out_pulse <= 1'b0;
         out_sign  <= 1'b0;
         fault     <= 1'b0;
      end else begin
         out_pulse <= emit;
         if (emit)            out_sign <= (carry == CY_DOWN);
         if (carry == CY_BAD) fault    <= 1'b1;
      end
   end
endmodule

// File: rtl/hyb_int_digital.sv
module hyb_int_digital
   import hyb_pkg::*;
#(
   parameter int IW       = 5,
   parameter int RW       = 7,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_reset,
   input  logic          init_load,
   input  logic [IW:0]   ic_integrand,
   input  logic [RW:0]   ic_remainder,
   input  logic          in_hold,
   input  logic          stb_inc,
   input  logic          stb_acc,
   input  logic          stb_carry,
   input  logic          inc_pulse,
   input  logic          inc_sign,
   input  logic          cmp_hi,
   input  logic          cmp_lo,
   output logic [IW:0]   integrand,
   output logic [RW:0]   remainder,
   output logic          out_pulse,
   output logic          out_sign,
   output logic          fault,
   output logic          ovf
);
   generate
      if (IW < 1) begin : g_bad_iw
         $error("hyb_int_digital: IW must be at least 1");
      end
      if (RW < IW + 2) begin : g_bad_rw
         $error("hyb_int_digital: RW must be at least IW+2");
      end
   endgenerate

   logic   hold_ok;
   logic   int_ovf;
   logic   rem_ovf;
   carry_e carry;

   assign hold_ok = in_hold & ~in_reset;

   hyb_integrand_reg #(.IW(IW), .SATURATE(SATURATE)) u_int (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_reset  (in_reset),
      .init_load (init_load),
      .ic_val    (ic_integrand),
      .inc_pulse (inc_pulse),
      .inc_sign  (inc_sign),
      .step_en   (hold_ok & stb_inc),
      .val       (integrand),
      .ovf_evt   (int_ovf)
   );

   hyb_carry_unit u_cy (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_reset  (in_reset),
      .fire      (hold_ok & stb_carry),
      .cmp_hi    (cmp_hi),
      .cmp_lo    (cmp_lo),
      .carry     (carry),
      .out_pulse (out_pulse),
      .out_sign  (out_sign),
      .fault     (fault)
   );

   hyb_remainder_reg #(.IW(IW), .RW(RW), .SATURATE(SATURATE)) u_rem (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_reset  (in_reset),
      .init_load (init_load),
      .ic_val    (ic_remainder),
      .acc_en    (hold_ok & stb_acc),
      .integrand (integrand),
      .carry     (carry),
      .val       (remainder),
      .ovf_evt   (rem_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf <= 1'b0;
      else if (in_reset) ovf <= 1'b0;
      else               ovf <= ovf | int_ovf | rem_ovf;
   end
endmodule

// File: rtl/hyb_int_digital_chk.sv
module hyb_int_digital_chk #(
   parameter int IW = 5,
   parameter int RW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_reset,
   input logic          init_load,
   input logic [IW:0]   ic_integrand,
   input logic [RW:0]   ic_remainder,
   input logic          in_hold,
   input logic          stb_inc,
   input logic          stb_acc,
   input logic          stb_carry,
   input logic          cmp_hi,
   input logic          cmp_lo,
   input logic [IW:0]   integrand,
   input logic [RW:0]   remainder,
   input logic          out_pulse,
   input logic          out_sign,
   input logic          fault,
   input logic          ovf
);
   logic          hold_ok;
   logic [RW+1:0] acc_wide;
   logic          acc_fits;

   assign hold_ok  = in_hold & ~in_reset;
   assign acc_wide = {remainder[RW], remainder} + {{(RW+1-IW){integrand[IW]}}, integrand};
   assign acc_fits = (acc_wide[RW+1] == acc_wide[RW]);

   assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_reset && !init_load) |=> (integrand == '0 && remainder == '0 && !fault && !ovf && !out_pulse));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_reset && init_load) |=> (integrand == $past(ic_integrand) && remainder == $past(ic_remainder)));

   assert_int_only_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_reset && !(in_hold && stb_inc)) |=> $stable(integrand));

   assert_accumulate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ok && stb_acc && !stb_carry && acc_fits) |=> (remainder == $past(acc_wide[RW:0])));

   assert_carry_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ok && stb_carry && cmp_hi && !cmp_lo) |=> (out_pulse && !out_sign));

   assert_carry_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ok && stb_carry && !cmp_hi && cmp_lo) |=> (out_pulse && out_sign));

   assert_pulse_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_pulse |-> $past(hold_ok && stb_carry));

   assert_both_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ok && stb_carry && cmp_hi && cmp_lo) |=> (fault && !out_pulse && $stable(remainder)));

   assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !in_reset) |=> fault);

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !in_reset) |=> ovf);

   assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_reset && !in_hold) |=> ($stable(integrand) && $stable(remainder)));
endmodule

bind hyb_int_digital hyb_int_digital_chk #(.IW(IW), .RW(RW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_reset     (in_reset),
   .init_load    (init_load),
   .ic_integrand (ic_integrand),
   .ic_remainder (ic_remainder),
   .in_hold      (in_hold),
   .stb_inc      (stb_inc),
   .stb_acc      (stb_acc),
   .stb_carry    (stb_carry),
   .cmp_hi       (cmp_hi),
   .cmp_lo       (cmp_lo),
   .integrand    (integrand),
   .remainder    (remainder),
   .out_pulse    (out_pulse),
   .out_sign     (out_sign),
   .fault        (fault),
   .ovf          (ovf)
);

// File: tb/hyb_int_digital_bench.sv
module hyb_int_digital_bench;
   localparam int IW   = 5;
   localparam int RW   = 7;
   localparam int IMAX = (1 << IW) - 1;
   localparam int IMIN = -(1 << IW);
   localparam int RMAX = (1 << RW) - 1;
   localparam int RMIN = -(1 << RW);
   localparam int UNIT = 1 << (IW + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_reset = 1'b0, init_load = 1'b0, in_hold = 1'b0;
   logic stb_inc = 1'b0, stb_acc = 1'b0, stb_carry = 1'b0;
   logic inc_pulse = 1'b0, inc_sign = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
   logic signed [IW:0] ic_integrand = '0;
   logic signed [RW:0] ic_remainder = '0;
   logic signed [IW:0] integrand;
   logic signed [RW:0] remainder;
   logic out_pulse, out_sign, fault, ovf;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   int m_int = 0, m_rem = 0;
   bit m_pend = 0, m_psign = 0, m_fault = 0, m_ovf = 0, m_pulse = 0, m_osign = 0;

   always #10 clk = ~clk;

   hyb_int_digital #(.IW(IW), .RW(RW)) u_hyb_int_digital (
      .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .init_load(init_load),
      .ic_integrand(ic_integrand), .ic_remainder(ic_remainder), .in_hold(in_hold),
      .stb_inc(stb_inc), .stb_acc(stb_acc), .stb_carry(stb_carry),
      .inc_pulse(inc_pulse), .inc_sign(inc_sign), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
      .integrand(integrand), .remainder(remainder), .out_pulse(out_pulse),
      .out_sign(out_sign), .fault(fault), .ovf(ovf)
   );

   function automatic int clip(input int v, input int lo, input int hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   function automatic bit outside(input int v, input int lo, input int hi);
      return (v > hi) || (v < lo);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      in_reset = 0; init_load = 0; in_hold = 0; stb_inc = 0; stb_acc = 0;
      stb_carry = 0; inc_pulse = 0; inc_sign = 0; cmp_hi = 0; cmp_lo = 0;
   endtask

   task automatic run(input string tag_in);
      string tag;
      int t;
      if (tag_in != "") tag = tag_in;
      else if (in_reset) tag = init_load ? "R2" : "R1";
      else if (!in_hold) tag = "R10";
      else if (stb_inc) tag = "R3";
      else if (stb_acc) tag = "R4";
      else if (stb_carry) tag = (cmp_hi && cmp_lo) ? "R7" : ((cmp_hi || cmp_lo) ? "R5" : "R6");
      else tag = "R10";
      @(posedge clk);
      m_pulse = 0;
      if (in_reset) begin
         m_int = init_load ? int'(ic_integrand) : 0;
         m_rem = init_load ? int'(ic_remainder) : 0;
         m_pend = 0; m_psign = 0; m_fault = 0; m_ovf = 0; m_osign = 0;
      end else begin
         if (in_hold && stb_inc && m_pend) begin
            t = m_int + (m_psign ? -1 : 1);
            if (outside(t, IMIN, IMAX)) m_ovf = 1;
            m_int = clip(t, IMIN, IMAX);
         end
         if (inc_pulse) begin
            m_pend = 1; m_psign = inc_sign;
         end else if (in_hold && stb_inc) begin
            m_pend = 0;
         end
         if (in_hold && stb_acc) begin
            t = m_rem + m_int;
            if (outside(t, RMIN, RMAX)) m_ovf = 1;
            m_rem = clip(t, RMIN, RMAX);
         end
         if (in_hold && stb_carry) begin
            if (cmp_hi && cmp_lo) m_fault = 1;
            else if (cmp_hi || cmp_lo) begin
               t = m_rem + (cmp_hi ? -UNIT : UNIT);
               if (outside(t, RMIN, RMAX)) m_ovf = 1;
               m_rem = clip(t, RMIN, RMAX);
               m_pulse = 1; m_osign = cmp_lo;
            end
         end
      end
      @(negedge clk);
      check(tag, "integrand", int'(integrand), m_int);
      check(tag, "remainder", int'(remainder), m_rem);
      check(tag, "out_pulse", int'(out_pulse), int'(m_pulse));
      check(tag, "fault", int'(fault), int'(m_fault));
      check(tag, "ovf", int'(ovf), int'(m_ovf));
      if (m_pulse) check(tag, "out_sign", int'(out_sign), int'(m_osign));
      clear_inputs();
   endtask

   task automatic load(input int iv, input int rv);
      in_reset = 1; init_load = 1;
      ic_integrand = IW'(iv) ; ic_remainder = RW'(rv);
      ic_integrand = iv[IW:0]; ic_remainder = rv[RW:0];
      run("R2");
   endtask

   task automatic pulse_in(input bit neg);
      inc_pulse = 1; inc_sign = neg; run("");
   endtask

   task automatic strobe(input int which, input bit hi, input bit lo, input string tag);
      in_hold = 1; cmp_hi = hi; cmp_lo = lo;
      stb_inc = (which == 0); stb_acc = (which == 1); stb_carry = (which == 2);
      run(tag);
   endtask

   task automatic random_frame();
      int ncomp;
      int pidx;
      bit hi, lo;
      int r;
      ncomp = 1 + int'($urandom % 3);
      pidx  = int'($urandom % 4);
      for (int c = 0; c < ncomp; c++) begin
         r = int'($urandom % 4);
         stb_inc = (r == 1); stb_acc = (r == 2); stb_carry = (r == 3);
         cmp_hi = $urandom % 2; cmp_lo = $urandom % 2;
         if (c == pidx) begin inc_pulse = 1; inc_sign = $urandom % 2; end
         run("");
      end
      strobe(0, 0, 0, "");
      strobe(1, 0, 0, "");
      r = int'($urandom % 16);
      if (r == 0) begin hi = 1; lo = 1; end
      else if (r < 4) begin hi = $urandom % 2; lo = ~hi; end
      else begin hi = (m_rem >= UNIT / 2); lo = (m_rem <= -UNIT / 2); end
      strobe(2, hi, lo, "");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = int'($urandom(32'd20250611));
      clear_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      check("R1", "reset integrand", int'(integrand), 0);
      check("R1", "reset remainder", int'(remainder), 0);
      check("R1", "reset fault", int'(fault), 0);
      check("R1", "reset ovf", int'(ovf), 0);

      // directed: main path
      load(5, -3);
      pulse_in(0);
      strobe(0, 0, 0, "R3");                 // integrand 6
      strobe(1, 0, 0, "R4");                 // remainder 3
      strobe(2, 1, 0, "R5");                 // remainder -61, pulse up
      stb_acc = 1; run("R10");               // ignored outside HOLD
      stb_inc = 1; run("R10");
      strobe(2, 0, 1, "R5");                 // remainder 3, pulse down
      strobe(0, 0, 0, "R3");                 // nothing pending
      strobe(2, 0, 0, "R6");
      strobe(2, 1, 1, "R7");                 // fault
      strobe(1, 0, 0, "R7");                 // fault stays
      in_hold = 1; in_reset = 1; stb_acc = 1; run("R1");   // reset wins, clears fault

      // integrand saturation
      load(IMAX, 0); pulse_in(0); strobe(0, 0, 0, "R8");
      load(IMIN, 0); pulse_in(1); strobe(0, 0, 0, "R8");
      // remainder saturation
      load(20, 120);  strobe(1, 0, 0, "R9");
      load(-20, -120); strobe(1, 0, 0, "R9");
      load(0, -100);  strobe(2, 1, 0, "R9");
      load(0, 100);   strobe(2, 0, 1, "R9");
      in_reset = 1; run("R1");

      for (int f = 0; f < 400; f++) begin
         if (($urandom % 40) == 0) begin
            in_reset = 1; init_load = $urandom % 2;
            ic_integrand = $urandom; ic_remainder = $urandom;
            run("");
         end
         random_frame();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule